// File: doc/BRIEF.md
# Timer-Paced SPI Byte Transfer Controller

This controller runs a complete eight-bit serial exchange, in either the clock-driving role or the clock-following role. The serial timing is SPI mode 0: the serial clock idles low, input bits are sampled on its rising edge, output bits change on its falling edge, and the most significant bit goes first.

In the driving role, an accepted put loads the outgoing byte and clears the completion state. It also starts an internal tick generator whose period is a programmable number of system clocks. Every tick flips the serial clock. After sixteen flips, which is eight full pulses, the tick generator halts and the assembled input byte is copied into a holding register. The holding register keeps that byte until the next completion.

In the following role, a put only stages the outgoing byte, and the exchange advances on edges of an external serial clock. The external clock passes through a synchronizer first. A put issued while a transfer is still running is refused and raises a sticky collision flag. The put and data inputs form a plain strobe interface with no back-pressure: refusal is reported through the collision flag rather than by stalling.

Top module: `spi_byte_ctrl`

## Requirements
- R1: After reset, busy, done and collision are 0, the held byte is 0x00 and the serial clock output is low.
- R2: A put while busy is 0 is accepted. From the next cycle, busy is 1, done is 0 and collision is 0.
- R3: A put while busy is 1 is refused. Collision is 1 from the next cycle, the put data is ignored, and the running transfer finishes with its original bytes.
- R4: Collision stays set until an accepted put or a one-cycle clear strobe. A clear and a refused put in the same cycle leave it set.
- R5: In the driving role, with period P system clocks (P of 0 acts as 1), the serial clock flips every P cycles. The first flip comes P cycles after the accepting edge. Done rises exactly 16*P cycles after the accepting edge.
- R6: The outgoing byte appears on the serial output MSB first and changes only on falling serial-clock edges. The incoming byte is sampled MSB first on rising edges.
- R7: On completion, busy falls and done rises in the same cycle. Done is never 1 while busy is 1.
- R8: When idle in the driving role, the serial clock output is low.
- R9: In the following role, the serial clock output stays low. The exchange is clocked by the external clock, and done rises on the third system-clock edge after the external clock's final falling transition.
- R10: External clock edges while busy is 0 have no effect: done and the held byte do not change.
- R11: The held byte changes only in the cycle done rises, and it keeps its value while the serial input moves afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| role_master_i | input | 1 | 1 = drive the serial clock, 0 = follow the external clock |
| tick_period_i | input | 16 | System clocks per serial-clock half period |
| put_i | input | 1 | One-cycle put strobe |
| put_data_i | input | 8 | Byte to send, taken on an accepted put |
| clr_coll_i | input | 1 | Clears the collision flag |
| sck_i | input | 1 | External serial clock (following role) |
| ser_in_i | input | 1 | Serial data in |
| sck_o | output | 1 | Generated serial clock (driving role) |
| ser_out_o | output | 1 | Serial data out |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Sticky completion flag |
| coll_o | output | 1 | Sticky write-collision flag |
| rx_byte_o | output | 8 | Last completed incoming byte |

## Verification
In the driving role, done is due exactly 16*P system-clock edges after the edge that takes the put. In the following role, it is due on the third edge after the bench lowers the external clock for the last time. The driver stores that cycle number with the expected bytes in a scoreboard entry. The monitor samples on the falling system-clock edge, compares the cycle counter when done rises, and then checks both bytes. Collision is checked one cycle after a refused put, and again after the clear strobe.

// File: rtl/sxc_pkg.sv
package sxc_pkg;
  localparam int BYTE_W = 8;
  localparam int PER_W  = 16;

  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_edge_t;
endpackage

// File: rtl/sxc_tick_gen.sv
module sxc_tick_gen #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign tick    = run && (cnt_inc >= {1'b0, period});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (restart || !run)    cnt_q <= '0;
    else if (tick)               cnt_q <= '0;
    else                         cnt_q <= cnt_inc[PER_W-1:0];
  end
endmodule

// File: rtl/sxc_edge_sync.sv
module sxc_edge_sync
  import sxc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  output sclk_edge_t edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o.rise = sync_q[STAGES-1] & ~prev_q;
  assign edge_o.fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/sxc_shift_unit.sv
module sxc_shift_unit
  import sxc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          enable,
  input  sclk_edge_t    edge_i,
  input  logic          ser_in,
  output logic          ser_out,
  output logic          last,
  output logic [DW-1:0] word
);
  localparam int EDGES = 2 * DW;
  localparam int CW    = $clog2(EDGES);

  logic [DW-1:0] sr_q;
  logic          samp_q;
  logic [CW-1:0] ecnt_q;
  logic          any_edge;

  assign any_edge = enable && (edge_i.rise || edge_i.fall);
  assign last     = enable && edge_i.fall && (ecnt_q == CW'(EDGES - 1));
  assign word     = {sr_q[DW-2:0], samp_q};
  assign ser_out  = sr_q[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      samp_q <= 1'b0;
      ecnt_q <= '0;
    end else if (load) begin
      sr_q   <= load_data;
      samp_q <= 1'b0;
      ecnt_q <= '0;
    end else if (any_edge) begin
      ecnt_q <= ecnt_q + 1'b1;
      if (edge_i.rise) samp_q <= ser_in;
      if (edge_i.fall) sr_q   <= word;
    end
  end
endmodule

// File: rtl/spi_byte_ctrl.sv
module spi_byte_ctrl
  import sxc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              role_master_i,
  input  logic [PER_W-1:0]  tick_period_i,
  input  logic              put_i,
  input  logic [BYTE_W-1:0] put_data_i,
  input  logic              clr_coll_i,
  input  logic              sck_i,
  input  logic              ser_in_i,
  output logic              sck_o,
  output logic              ser_out_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              coll_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  logic              busy_q, done_q, coll_q, sck_q;
  logic [BYTE_W-1:0] rx_q;
  logic              accept, tick, last;
  logic [BYTE_W-1:0] word;
  sclk_edge_t        ext_edge, int_edge, sel_edge;

  assign accept = put_i && !busy_q;

  sxc_tick_gen #(.PER_W(PER_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy_q && role_master_i),
    .restart(accept), .period(tick_period_i), .tick(tick)
  );

  sxc_edge_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(sck_i), .edge_o(ext_edge)
  );

  assign int_edge.rise = tick && !sck_q;
  assign int_edge.fall = tick && sck_q;
  assign sel_edge      = role_master_i ? int_edge : ext_edge;

  sxc_shift_unit #(.DW(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_data(put_data_i),
    .enable(busy_q), .edge_i(sel_edge), .ser_in(ser_in_i),
    .ser_out(ser_out_o), .last(last), .word(word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sck_q <= 1'b0;
    else if (accept) sck_q <= 1'b0;
    else if (tick)   sck_q <= ~sck_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      coll_q <= 1'b0;
      rx_q   <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      coll_q <= 1'b0;
    end else begin
      if (put_i)           coll_q <= 1'b1;
      else if (clr_coll_i) coll_q <= 1'b0;
      if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        rx_q   <= word;
      end
    end
  end

  assign sck_o     = sck_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign coll_o    = coll_q;
  assign rx_byte_o = rx_q;
endmodule

// File: rtl/sxc_checker.sv
module sxc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       role_master_i,
  input logic       put_i,
  input logic       clr_coll_i,
  input logic       sck_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       coll_o,
  input logic [7:0] rx_byte_o
);
  p_busy_after_put_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (put_i && !busy_o) |=> (busy_o && !done_o && !coll_o));

  p_coll_on_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (put_i && busy_o) |=> coll_o);

  p_coll_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_o && !put_i && !clr_coll_i) |=> coll_o);

  p_done_excl_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_idle_sck_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && role_master_i) |-> !sck_o);

  p_rx_on_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_byte_o != $past(rx_byte_o)) |-> $rose(done_o));
endmodule

bind spi_byte_ctrl sxc_checker u_sxc_checker (
  .clk(clk), .rst_n(rst_n), .role_master_i(role_master_i), .put_i(put_i),
  .clr_coll_i(clr_coll_i), .sck_o(sck_o), .busy_o(busy_o), .done_o(done_o),
  .coll_o(coll_o), .rx_byte_o(rx_byte_o)
);

// File: tb/test_spi_byte_ctrl.sv
module test_spi_byte_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct {
    logic [7:0] rx;
    logic [7:0] tx;
    int         due;
    logic       master;
    string      tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic role_m = 1'b1, put = 1'b0, clr = 1'b0, sck_in = 1'b0, slv_in = 1'b0;
  logic [15:0] period = 16'd1;
  logic [7:0] pdata = '0;
  logic sck_o, ser_out, busy, done, coll;
  logic [7:0] rx;
  logic ser_in;
  logic [7:0] sl_sr = '0, mosi_cap = '0, slv_cap = '0;
  int cyc = 0, checks = 0, errors = 0;
  logic done_d = 1'b0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb ser_in = role_m ? sl_sr[7] : slv_in;

  spi_byte_ctrl i_spi_byte_ctrl (
    .clk(clk), .rst_n(rst_n), .role_master_i(role_m), .tick_period_i(period),
    .put_i(put), .put_data_i(pdata), .clr_coll_i(clr), .sck_i(sck_in),
    .ser_in_i(ser_in), .sck_o(sck_o), .ser_out_o(ser_out), .busy_o(busy),
    .done_o(done), .coll_o(coll), .rx_byte_o(rx)
  );

  // bench-side peer for the driving role (mode 0)
  always @(negedge sck_o) sl_sr <= {sl_sr[6:0], 1'b0};
  always @(posedge sck_o) mosi_cap <= {mosi_cap[6:0], ser_out};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    done_d <= done;
    if (rst_n && done && !done_d) begin
      if (q.size() == 0) check(1'b0, "R7 unexpected done", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        check(cyc == it.due, {it.tag, " done cycle"}, cyc, it.due);
        check(rx == it.rx, {it.tag, " rx byte"}, rx, it.rx);
        check((it.master ? mosi_cap : slv_cap) == it.tx, {it.tag, " tx byte"},
              it.master ? mosi_cap : slv_cap, it.tx);
        check(!busy, "R7 busy low at done", busy, 0);
      end
    end
  end

  always @(posedge clk) if (cyc > WATCHDOG) begin
    check(1'b0, "watchdog", cyc, WATCHDOG);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic pulse_put(input logic [7:0] d);
    @(negedge clk); put = 1'b1; pdata = d;
    @(negedge clk); put = 1'b0;
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] peer,
                             input int p, input string tag);
    item_t it;
    int eff;
    eff = (p == 0) ? 1 : p;
    @(negedge clk);
    role_m = 1'b1; period = 16'(p); sl_sr = peer;
    put = 1'b1; pdata = tx;
    it.rx = peer; it.tx = tx; it.due = cyc + 1 + 16 * eff;
    it.master = 1'b1; it.tag = tag;
    q.push_back(it);
    @(negedge clk); put = 1'b0;
    check(busy && !done && !coll, "R2 accepted put", {busy, done, coll}, 3'b100);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic slave_xfer(input logic [7:0] tx, input logic [7:0] peer, input string tag);
    item_t it;
    @(negedge clk);
    role_m = 1'b0; put = 1'b1; pdata = tx;
    @(negedge clk); put = 1'b0;
    repeat (6) @(negedge clk);
    check(!sck_o && busy, "R9 no clock generated in following role", sck_o, 0);
    for (int i = 7; i >= 0; i--) begin
      slv_in = peer[i];
      repeat (4) @(negedge clk);
      slv_cap = {slv_cap[6:0], ser_out};
      sck_in = 1'b1;
      repeat (4) @(negedge clk);
      sck_in = 1'b0;
      if (i == 0) begin
        it.rx = peer; it.tx = tx; it.due = cyc + 3; it.master = 1'b0; it.tag = tag;
        q.push_back(it);
      end
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !coll && rx == 8'h00 && !sck_o, "R1 reset state",
          {busy, done, coll, sck_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 R6 driving role, several periods including 0
    master_xfer(8'hA5, 8'h3C, 1, "R5 R6 P=1");   wait_idle();
    check(!sck_o, "R8 clock idle low", sck_o, 0);
    master_xfer(8'h81, 8'hE7, 3, "R5 R6 P=3");   wait_idle();
    master_xfer(8'h5A, 8'h01, 0, "R5 R11 P=0");  wait_idle();

    // R11 held byte stable while the serial input moves
    sl_sr = 8'hFF;
    repeat (5) @(negedge clk);
    check(rx == 8'h01 && done, "R11 held byte stable", rx, 8'h01);

    // R3 refused put during transfer
    master_xfer(8'hC3, 8'h96, 2, "R3 transfer under collision");
    repeat (8) @(negedge clk);
    pulse_put(8'hFF);
    check(coll && busy, "R3 collision raised", coll, 1);
    wait_idle();
    check(coll, "R4 collision sticky after done", coll, 1);
    @(negedge clk); clr = 1'b1; put = 1'b0;
    @(negedge clk); clr = 1'b0;
    check(!coll, "R4 clear strobe", coll, 0);

    // R4 accepted put clears collision
    master_xfer(8'h11, 8'h22, 1, "R4 setup");
    repeat (3) @(negedge clk);
    pulse_put(8'h00);
    wait_idle();
    check(coll, "R4 set before accepted put", coll, 1);
    master_xfer(8'h7E, 8'hB1, 1, "R4 accept clears");
    check(!coll, "R4 accepted put cleared collision", coll, 0);
    wait_idle();

    // R10 external edges while idle
    role_m = 1'b0;
    for (int k = 0; k < 4; k++) begin
      sck_in = 1'b1; repeat (4) @(negedge clk);
      sck_in = 1'b0; repeat (4) @(negedge clk);
    end
    check(rx == 8'hB1 && done && !busy, "R10 idle edges ignored", rx, 8'hB1);

    // R9 following role
    slave_xfer(8'h6D, 8'h9A, "R9 following A");
    slave_xfer(8'hF0, 8'h0F, "R9 following B");

    repeat (10) @(negedge clk);
    check(q.size() == 0, "R7 all completions seen", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule